// File: doc/BRIEF.md
# Tamper Security State Controller

This block is the decision core of a security monitor that sits in an always-on power domain. It watches nine tamper sources and records each one that is enabled into a sticky status bit. The sources are a wire-mesh sensor, two external tamper pins, temperature, clock, voltage, an overflow of its own time counter, an overflow of an external monotonic counter, and an external boot indication. Any enabled source forces the unit into a failure condition. While failed, the time counter stops, so the moment of the violation stays readable.

Two flags describe the unit: non-valid and failure. A battery-domain reset leaves the unit non-valid. Software recovers a failed unit in a fixed order: it clears the status bits, then the failure flag, and last the non-valid flag, which returns the unit to the valid state. A unit that is failed but valid accepts no recovery commands. A system power-on reset moves it back to non-valid so that recovery can run, unless the hard-lock bit is set. With the lock set, only a battery reset clears the unit.

Commands arrive as single-cycle writes on a plain control port. Nothing streams into or out of this block, so it has no valid/ready handshake.

Top module: `tamper_guard`

## Requirements
- R1: After the battery reset (`rst_n` low) the outputs read non-valid 1, failure 0, locked 0, irq 0, status all zero and time zero.
- R2: An event input bit that is high while its enable bit is set does two things at the next clock edge: it sets the matching status bit and it sets failure. An event whose enable is clear changes nothing.
- R3: Status bits are sticky. A write with command 1 clears the status bits whose data bits are one, but only while non-valid. While valid, that write is ignored.
- R4: A write with command 0 loads the event enable mask from data, but only while non-valid. While valid, it is ignored.
- R5: `time_o` increments by one on each cycle with `tick_i` high while failure is clear. It holds its value while failure is set.
- R6: A tick taken while `time_o` is all ones wraps the counter to zero and raises event bit 6 (time overflow), which is ORed with `evt_i[6]`.
- R7: `sys_por_i` sets non-valid only while failed with lock clear. With lock set, or while not failed, it changes nothing.
- R8: A write with command 3 clears failure only when all of these hold: non-valid is 1, lock is 0, status is all zero, and no enabled event is present in that cycle.
- R9: A write with command 4 clears non-valid only when failure is 0 and no enabled event is present in that cycle.
- R10: A write with command 2 and data bit 0 set sets the lock. Only the battery reset clears it.
- R11: A write with command 5 loads the interrupt enable from data bit 0 and, if data bit 1 is set, clears irq. irq sets when failure is entered while the interrupt enable is set, and it holds until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Battery-domain reset, active low, asynchronous |
| sys_por_i | input | 1 | System power-on reset indication, synchronous pulse |
| tick_i | input | 1 | Time counter increment strobe |
| evt_i | input | 9 | Tamper event levels, bit 0 mesh, 1 pin A, 2 pin B, 3 temperature, 4 clock, 5 voltage, 6 time overflow, 7 monotonic overflow, 8 external boot |
| wr_en_i | input | 1 | Command write strobe |
| wr_sel_i | input | 3 | Command code (0 to 5) |
| wr_data_i | input | 9 | Command data |
| nonvalid_o | output | 1 | Non-valid flag |
| failure_o | output | 1 | Failure flag |
| locked_o | output | 1 | Hard-lock bit |
| irq_o | output | 1 | Security violation interrupt |
| status_o | output | 9 | Sticky event status |
| time_o | output | TW | Time counter value |

## Verification
The bench runs the recovery sequence out of order. It tries to clear the non-valid flag while still failed, and to clear failure while status bits are set, in the valid state or with the lock set. A design that ignores any of these conditions would drop the unit into the valid state with its cause still recorded. It pulses the system reset in both lock states: a wrong design would either stay stuck with no way to recover or escape the battery-only lock. It drives the counter through its wrap point and keeps ticking after failure, which catches a missing overflow event or a counter that keeps running while failed. Seeded random traffic is compared cycle by cycle with a model written from the requirements. This exposes set-versus-clear priority errors on the same edge.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int NUM_EVT      = 9;
  localparam int EVT_TIME_OVF = 6;

  typedef enum logic [2:0] {
    CMD_SET_EN   = 3'd0,
    CMD_CLR_STAT = 3'd1,
    CMD_SET_LOCK = 3'd2,
    CMD_CLR_FAIL = 3'd3,
    CMD_CLR_NV   = 3'd4,
    CMD_IRQ_CTRL = 3'd5
  } tg_cmd_e;
endpackage

// File: rtl/tg_time_ctr.sv
module tg_time_ctr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  output logic [TW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [TW-1:0] cnt_q;
  logic          step;

  assign step  = tick_i && run_i;
  assign ovf_o = step && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // R5: a stopped counter keeps its value
  p_frozen_when_failed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/tg_evt_latch.sv
module tg_evt_latch #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         nv_i,
  input  logic         set_en_i,
  input  logic         clr_stat_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] hit_o,
  output logic [N-1:0] status_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_q <= '0;
    else if (set_en_i && nv_i)   en_q <= data_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hit_o[i] = evt_i[i] & en_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             status_q[i] <= 1'b0;
      else if (hit_o[i])                      status_q[i] <= 1'b1;
      else if (clr_stat_i && nv_i && data_i[i]) status_q[i] <= 1'b0;
    end
  end

  assign status_o = status_q;

  // R2: every enabled event lands in its status bit
  p_hit_recorded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> ((status_q & $past(hit_o)) == $past(hit_o)));
  // R3: no status bit drops while the unit is valid
  p_sticky_when_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/tg_state_fsm.sv
module tg_state_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_any_i,
  input  logic status_zero_i,
  input  logic por_i,
  input  logic lock_set_i,
  input  logic clr_fail_i,
  input  logic clr_nv_i,
  input  logic irq_wr_i,
  input  logic irq_en_d_i,
  input  logic irq_ack_i,
  output logic nv_o,
  output logic fail_o,
  output logic lock_o,
  output logic irq_o
);
  logic nv_q, fail_q, lock_q, irq_en_q, irq_q;
  logic clr_fail_ok, clr_nv_ok, reopen;

  assign clr_fail_ok = clr_fail_i && nv_q && !lock_q && status_zero_i && !hit_any_i;
  assign clr_nv_ok   = clr_nv_i && !fail_q && !hit_any_i;
  assign reopen      = por_i && fail_q && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q     <= 1'b1;
      fail_q   <= 1'b0;
      lock_q   <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      lock_q <= lock_q | lock_set_i;
      if (hit_any_i)        fail_q <= 1'b1;
      else if (clr_fail_ok) fail_q <= 1'b0;
      if (reopen)           nv_q <= 1'b1;
      else if (clr_nv_ok)   nv_q <= 1'b0;
      if (irq_wr_i)         irq_en_q <= irq_en_d_i;
      if (hit_any_i && !fail_q && irq_en_q) irq_q <= 1'b1;
      else if (irq_wr_i && irq_ack_i)       irq_q <= 1'b0;
    end
  end

  assign nv_o   = nv_q;
  assign fail_o = fail_q;
  assign lock_o = lock_q;
  assign irq_o  = irq_q;

  // R10: lock never falls outside battery reset
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8: failure only clears from non-valid with lock clear
  p_fail_clear_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_q) |-> ($past(nv_q) && !$past(lock_q)));
  // R9: non-valid only clears once failure is gone
  p_nv_clear_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_q) |-> !$past(fail_q));
  // R11: interrupt rises only together with failure entry
  p_irq_on_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $rose(fail_q));
  // R7: a locked unit ignores the system reset
  p_locked_por_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !nv_q) |=> !nv_q);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter int N_EVT = tg_pkg::NUM_EVT,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_por_i,
  input  logic             tick_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [N_EVT-1:0] wr_data_i,
  output logic             nonvalid_o,
  output logic             failure_o,
  output logic             locked_o,
  output logic             irq_o,
  output logic [N_EVT-1:0] status_o,
  output logic [TW-1:0]    time_o
);
  import tg_pkg::*;

  localparam int OVF_BIT = EVT_TIME_OVF;

  tg_cmd_e          cmd;
  logic             do_en, do_stat, do_lock, do_fail, do_nv, do_irq;
  logic             ovf;
  logic [N_EVT-1:0] evt_all, hit, status;
  logic             nv, fail;

  assign cmd     = tg_cmd_e'(wr_sel_i);
  assign do_en   = wr_en_i && (cmd == CMD_SET_EN);
  assign do_stat = wr_en_i && (cmd == CMD_CLR_STAT);
  assign do_lock = wr_en_i && (cmd == CMD_SET_LOCK) && wr_data_i[0];
  assign do_fail = wr_en_i && (cmd == CMD_CLR_FAIL);
  assign do_nv   = wr_en_i && (cmd == CMD_CLR_NV);
  assign do_irq  = wr_en_i && (cmd == CMD_IRQ_CTRL);

  always_comb begin
    evt_all          = evt_i;
    evt_all[OVF_BIT] = evt_i[OVF_BIT] | ovf;
  end

  tg_time_ctr #(.TW(TW)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(!fail),
    .cnt_o(time_o), .ovf_o(ovf)
  );

  tg_evt_latch #(.N(N_EVT)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_all), .nv_i(nv),
    .set_en_i(do_en), .clr_stat_i(do_stat), .data_i(wr_data_i),
    .hit_o(hit), .status_o(status)
  );

  tg_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_any_i(|hit), .status_zero_i(status == '0),
    .por_i(sys_por_i), .lock_set_i(do_lock), .clr_fail_i(do_fail),
    .clr_nv_i(do_nv), .irq_wr_i(do_irq), .irq_en_d_i(wr_data_i[0]),
    .irq_ack_i(wr_data_i[1]), .nv_o(nv), .fail_o(fail), .lock_o(locked_o),
    .irq_o(irq_o)
  );

  assign nonvalid_o = nv;
  assign failure_o  = fail;
  assign status_o   = status;

  // R2: an enabled event always ends in failure
  p_fail_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> fail);
  // R6: the overflow step returns the counter to zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (time_o == '0));
endmodule

// File: tb/sim_tamper_guard.sv
module sim_tamper_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  localparam int N = 9;

  logic clk = 1'b0, rst_n = 1'b0, sys_por = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [N-1:0] evt = '0, wr_data = '0;
  logic [2:0] wr_sel = '0;
  logic nonvalid, failure, locked, irq;
  logic [N-1:0] status;
  logic [TW-1:0] time_v;
  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model state
  logic m_nv, m_fail, m_lock, m_irqen, m_irq;
  logic [N-1:0] m_en, m_stat;
  logic [TW-1:0] m_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_guard #(.N_EVT(N), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_por_i(sys_por), .tick_i(tick), .evt_i(evt),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .nonvalid_o(nonvalid), .failure_o(failure), .locked_o(locked), .irq_o(irq),
    .status_o(status), .time_o(time_v)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_nv = 1; m_fail = 0; m_lock = 0; m_irqen = 0; m_irq = 0;
    m_en = '0; m_stat = '0; m_time = '0;
  endtask

  function automatic logic [N-1:0] model_hit(input logic [N-1:0] e, input logic tk);
    logic [N-1:0] ev = e;
    if (tk && !m_fail && (&m_time)) ev[6] = 1'b1;
    return ev & m_en;
  endfunction

  task automatic model_update(input logic [N-1:0] e, input logic tk, input logic we,
                              input logic [2:0] sel, input logic [N-1:0] d, input logic por);
    logic [N-1:0] h = model_hit(e, tk);
    logic n_nv = m_nv, n_fail = m_fail, n_irq = m_irq, n_irqen = m_irqen;
    logic [N-1:0] n_stat = m_stat, n_en = m_en;
    if (we && sel == 3'd1 && m_nv) n_stat = n_stat & ~d;
    n_stat = n_stat | h;
    if (we && sel == 3'd0 && m_nv) n_en = d;
    if (|h) n_fail = 1;
    else if (we && sel == 3'd3 && m_nv && !m_lock && m_stat == '0) n_fail = 0;
    if (por && m_fail && !m_lock) n_nv = 1;
    else if (we && sel == 3'd4 && !m_fail && h == '0) n_nv = 0;
    if (we && sel == 3'd5) n_irqen = d[0];
    if ((|h) && !m_fail && m_irqen) n_irq = 1;
    else if (we && sel == 3'd5 && d[1]) n_irq = 0;
    if (tk && !m_fail) m_time = m_time + 1'b1;
    if (we && sel == 3'd2 && d[0]) m_lock = 1;
    m_nv = n_nv; m_fail = n_fail; m_irq = n_irq; m_irqen = n_irqen;
    m_stat = n_stat; m_en = n_en;
  endtask

  task automatic step(input logic [N-1:0] e, input logic tk, input logic we,
                      input logic [2:0] sel, input logic [N-1:0] d, input logic por);
    @(negedge clk);
    evt = e; tick = tk; wr_en = we; wr_sel = sel; wr_data = d; sys_por = por;
    model_update(e, tk, we, sel, d, por);
    @(posedge clk); #1;
    evt = '0; tick = 0; wr_en = 0; wr_sel = '0; wr_data = '0; sys_por = 0;
  endtask

  task automatic cmd(input logic [2:0] sel, input logic [N-1:0] d);
    step('0, 0, 1, sel, d, 0);
  endtask

  task automatic bat_reset();
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic cmp_model();
    chk("R9 nonvalid", nonvalid, m_nv);
    chk("R2 failure", failure, m_fail);
    chk("R10 locked", locked, m_lock);
    chk("R11 irq", irq, m_irq);
    chk("R3 status", status, m_stat);
    chk("R5 time", time_v, m_time);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    bat_reset();
    // R1 reset state
    chk("R1 nonvalid", nonvalid, 1); chk("R1 failure", failure, 0);
    chk("R1 locked", locked, 0); chk("R1 irq", irq, 0);
    chk("R1 status", status, 0); chk("R1 time", time_v, 0);
    // R5 counting
    for (int i = 0; i < 5; i++) step('0, 1, 0, 0, 0, 0);
    chk("R5 count", time_v, 5);
    // R2 enabled event
    cmd(3'd0, 9'h1FF);
    step(9'h008, 0, 0, 0, 0, 0);
    chk("R2 status", status, 9'h008); chk("R2 failure", failure, 1);
    chk("R11 no irq when disabled", irq, 0);
    for (int i = 0; i < 3; i++) step('0, 1, 0, 0, 0, 0);
    chk("R5 frozen", time_v, 5);
    cmd(3'd4, 0); chk("R9 nv held while failed", nonvalid, 1);
    cmd(3'd3, 0); chk("R8 fail held with status", failure, 1);
    cmd(3'd1, 9'h008); chk("R3 clear in nonvalid", status, 0);
    cmd(3'd3, 0); chk("R8 fail cleared", failure, 0);
    cmd(3'd4, 0); chk("R9 nv cleared", nonvalid, 0);
    // R4 enable write ignored while valid
    cmd(3'd0, 9'h000);
    step(9'h001, 0, 0, 0, 0, 0);
    chk("R4 enable kept", failure, 1); chk("R4 status", status, 9'h001);
    cmd(3'd1, 9'h001); chk("R3 clear ignored when valid", status, 9'h001);
    cmd(3'd3, 0); chk("R8 fail held when valid", failure, 1);
    // R7 system reset reopens
    step('0, 0, 0, 0, 0, 1); chk("R7 por reopens", nonvalid, 1);
    cmd(3'd1, 9'h1FF); cmd(3'd3, 0); cmd(3'd4, 0);
    chk("R9 recovered", nonvalid, 0); chk("R8 recovered", failure, 0);
    step('0, 0, 0, 0, 0, 1); chk("R7 por no effect when ok", nonvalid, 0);
    // R11 interrupt
    cmd(3'd5, 9'h001);
    step(9'h100, 0, 0, 0, 0, 0); chk("R11 irq set", irq, 1);
    step(9'h100, 0, 0, 0, 0, 0); chk("R11 irq held", irq, 1);
    cmd(3'd5, 9'h003); chk("R11 irq ack", irq, 0);
    // R10 lock behaviour
    cmd(3'd2, 9'h001); chk("R10 lock set", locked, 1);
    step('0, 0, 0, 0, 0, 1); chk("R7 locked por ignored", nonvalid, 0);
    cmd(3'd2, 9'h000); chk("R10 lock sticky", locked, 1);
    bat_reset(); chk("R10 battery clears", locked, 0);
    // R6 overflow
    cmd(3'd0, 9'h040);
    for (int i = 0; i < 63; i++) step('0, 1, 0, 0, 0, 0);
    chk("R6 at max", time_v, 63);
    step('0, 1, 0, 0, 0, 0);
    chk("R6 wrap", time_v, 0); chk("R6 status", status, 9'h040);
    chk("R6 failure", failure, 1);
    cmpAll: begin cmp_model(); end
    // random phase against the model
    bat_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] e, d;
      logic [2:0] s;
      e = ($urandom % 10 == 0) ? N'(1) << ($urandom % N) : '0;
      s = 3'($urandom % 8);
      d = N'($urandom);
      step(e, 1'($urandom % 2), ($urandom % 3 == 0), s, d, ($urandom % 40 == 0));
      cmp_model();
      if ($urandom % 500 == 0) bat_reset();
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule